// File: doc/BRIEF.md
# Threshold-Stopped Channel Write Enable

This block produces the write enable for one channel of a monitor capture memory. A shared run enable, which rises on a turn boundary, opens capture for every channel. Each channel then either mirrors that run enable or keeps writing until its own data shows a pulse above a programmable level. After such a pulse the channel closes its enable on the next turn boundary, so the complete turn that holds the pulse stays in memory.

The raw sample stream first passes through a delay line whose length is selectable from zero to fifteen sample steps. The delayed sample feeds both the threshold comparator and the memory write data. A source selector chooses which stream goes to the downstream processing path: the delayed live samples or the playback samples read back from memory. The channel enable port also serves as the status bit that shows whether the channel is still capturing. Every clock cycle carries one sample.

Top module: `chan_capture_enable`

## Requirements
- R1: After reset, with `run_we` low, `chan_we` is 0, and every delayed tap reads 0, so `dly_sample` is 0 for any nonzero `delay_sel` until new samples have shifted in.
- R2: When `stop_mode` is 0, `chan_we` equals `run_we` in every cycle, whatever the samples are.
- R3: When `stop_mode` is 1 and no sample exceeds the threshold during a run, `chan_we` equals `run_we` in every cycle.
- R4: When `stop_mode` is 1 and `run_we` is high, a sample whose bits [9:2] exceed `thresh` keeps `chan_we` high for the rest of that turn. `chan_we` then goes low in the next cycle with `turn_start` high and stays low until `run_we` falls.
- R5: An over-threshold sample seen in the same cycle as `turn_start` does not stop the current turn. The stop takes effect at the following `turn_start`.
- R6: The comparison is strictly greater-than. A sample whose bits [9:2] equal `thresh` does not stop capture.
- R7: When `run_we` falls, `chan_we` is low in that same cycle, even if a stop is pending.
- R8: `dly_sample` equals the `raw_sample` value presented `delay_sel` cycles earlier. A `delay_sel` of 0 passes the current sample through in the same cycle.
- R9: `proc_data` equals `dly_sample` when `src_sel` is 0 and equals `play_sample` when `src_sel` is 1.
- R10: An over-threshold sample seen while `run_we` is low has no effect, and every new run starts with no pending or latched stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_sample | input | 10 | Live converter sample |
| play_sample | input | 10 | Playback sample from memory |
| delay_sel | input | 4 | Delay in sample steps, 0 to 15 |
| thresh | input | 8 | Stop level, compared with sample bits [9:2] |
| stop_mode | input | 1 | 0 = follow run enable, 1 = stop after a pulse |
| src_sel | input | 1 | 0 = delayed live data, 1 = playback data to processing |
| turn_start | input | 1 | Begin-of-turn marker, high for one cycle |
| run_we | input | 1 | Shared run write enable |
| dly_sample | output | 10 | Delayed sample, used as memory write data |
| proc_data | output | 10 | Selected data for the processing path |
| chan_we | output | 1 | Channel write enable, also the capture status |

## Verification
The collision that matters is an over-threshold sample arriving in the same cycle as a turn marker. The bench places the pulse on the marker cycle of a turn and checks that the enable survives that whole turn and falls only at the next marker. A second collision is the shared run enable falling while a stop is already armed. Here the bench ends the run inside the turn that holds the pulse and checks that the enable drops with the run enable, and that the next run starts clean. Every expected value comes from the turn and position index of each driven cycle.

// File: rtl/chwe_pkg.sv
package chwe_pkg;
  localparam int ADC_W   = 10;
  localparam int THR_W   = 8;
  localparam int MAX_DLY = 15;
endpackage

// File: rtl/sample_delay.sv
module sample_delay #(
  parameter int W     = chwe_pkg::ADC_W,
  parameter int DEPTH = chwe_pkg::MAX_DLY,
  localparam int SEL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     dout
);
  logic [W-1:0] stage_q [DEPTH];
  logic [W-1:0] stage_d [DEPTH];

  always_comb begin
    stage_d[0] = din;
    for (int k = 1; k < DEPTH; k++) begin
      stage_d[k] = stage_q[k-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d[g];
    end
  end

  always_comb begin
    dout = din;
    for (int k = 0; k < DEPTH; k++) begin
      if (int'(sel) == k + 1) dout = stage_q[k];
    end
  end

  // R8: one step of delay is the previous stage value
  p_one_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_W'(1)) |-> (dout == stage_q[0]));
endmodule

// File: rtl/pulse_tracker.sv
module pulse_tracker #(
  parameter int THR_W = chwe_pkg::THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] level,
  input  logic [THR_W-1:0] thresh,
  input  logic             run_we,
  input  logic             turn_start,
  output logic             armed,
  output logic             stopped
);
  logic over;
  logic armed_d, stopped_d;
  logic armed_q, stopped_q;

  always_comb begin
    over      = level > thresh;
    armed_d   = run_we & (armed_q | over);
    stopped_d = run_we & (stopped_q | (armed_q & turn_start));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      stopped_q <= stopped_d;
    end
  end

  assign armed   = armed_q;
  assign stopped = stopped_q;

  // R4: a pending stop persists while the run continues
  p_armed_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && run_we) |=> armed_q);
  // R10: an idle run leaves nothing pending
  p_idle_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_we |=> (!armed_q && !stopped_q));
  // R4: a latched stop implies a pulse was seen before it
  p_stop_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped_q) |-> $past(armed_q));
endmodule

// File: rtl/chan_capture_enable.sv
module chan_capture_enable #(
  parameter int ADC_W   = chwe_pkg::ADC_W,
  parameter int THR_W   = chwe_pkg::THR_W,
  parameter int MAX_DLY = chwe_pkg::MAX_DLY,
  localparam int SEL_W  = $clog2(MAX_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADC_W-1:0] raw_sample,
  input  logic [ADC_W-1:0] play_sample,
  input  logic [SEL_W-1:0] delay_sel,
  input  logic [THR_W-1:0] thresh,
  input  logic             stop_mode,
  input  logic             src_sel,
  input  logic             turn_start,
  input  logic             run_we,
  output logic [ADC_W-1:0] dly_sample,
  output logic [ADC_W-1:0] proc_data,
  output logic             chan_we
);
  logic armed, stopped;
  logic [ADC_W-1:0] dly;

  sample_delay #(.W(ADC_W), .DEPTH(MAX_DLY)) i_delay (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_sample),
    .sel  (delay_sel),
    .dout (dly)
  );

  pulse_tracker #(.THR_W(THR_W)) i_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (dly[ADC_W-1 -: THR_W]),
    .thresh    (thresh),
    .run_we    (run_we),
    .turn_start(turn_start),
    .armed     (armed),
    .stopped   (stopped)
  );

  always_comb begin
    dly_sample = dly;
    proc_data  = src_sel ? play_sample : dly;
    chan_we    = run_we & (~stop_mode | ~(stopped | (armed & turn_start)));
  end

  // R2: follow mode mirrors the run enable
  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_mode |-> (chan_we == run_we));
  // R7: no channel write without the run enable
  p_run_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_we |-> !chan_we);
  // R4: once stopped within a run, the channel does not restart
  p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && $past(stop_mode) && run_we && $past(run_we) && !$past(chan_we))
      |-> !chan_we);
  // R4: a drop inside a run happens only on a turn marker
  p_drop_on_marker_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && $past(stop_mode) && run_we && $past(chan_we) && !chan_we)
      |-> turn_start);
endmodule

// File: tb/test_chan_capture_enable.sv
module test_chan_capture_enable;
  localparam int PERIOD = 10;
  localparam int TL     = 6;
  localparam logic [7:0] THR = 8'h80;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] raw_sample, play_sample;
  logic [3:0] delay_sel;
  logic [7:0] thresh;
  logic       stop_mode, src_sel, turn_start, run_we;
  logic [9:0] dly_sample, proc_data;
  logic       chan_we;

  int n_chk = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  chan_capture_enable i_chan_capture_enable (
    .clk(clk), .rst_n(rst_n), .raw_sample(raw_sample), .play_sample(play_sample),
    .delay_sel(delay_sel), .thresh(thresh), .stop_mode(stop_mode), .src_sel(src_sel),
    .turn_start(turn_start), .run_we(run_we), .dly_sample(dly_sample),
    .proc_data(proc_data), .chan_we(chan_we)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [9:0] s, input logic b, input logic g);
    @(negedge clk);
    raw_sample = s;
    turn_start = b;
    run_we     = g;
    #2;
  endtask

  // One run of glob_turns turns; a hit sample at (hit_turn, hit_pos),
  // an equal-to-threshold sample at (eq_turn, 1). Then two idle cycles,
  // the first carrying an over-threshold sample while run_we is low.
  task automatic run(input logic mode, input int hit_turn, input int hit_pos,
                     input int glob_turns, input int eq_turn, input string req);
    stop_mode = mode;
    for (int t = 0; t < glob_turns; t++) begin
      for (int q = 0; q < TL; q++) begin
        logic [9:0] s;
        logic exp;
        s = 10'd3;
        if (t == hit_turn && q == hit_pos) s = {THR + 8'd1, 2'b00};
        if (t == eq_turn && q == 1)        s = {THR, 2'b11};
        step(s, q == 0, 1'b1);
        exp = mode ? !(hit_turn >= 0 && t > hit_turn) : 1'b1;
        check(chan_we == exp, req, chan_we, exp);
      end
    end
    step({THR + 8'd5, 2'b00}, 1'b0, 1'b0);
    check(chan_we == 1'b0, "R7", chan_we, 0);
    step(10'd0, 1'b1, 1'b0);
    check(chan_we == 1'b0, "R10", chan_we, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    raw_sample = 10'h3ff; play_sample = 10'h155; delay_sel = 4'd5;
    thresh = THR; stop_mode = 1'b1; src_sel = 1'b0; turn_start = 1'b0; run_we = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(chan_we == 1'b0, "R1", chan_we, 0);
    check(dly_sample == 10'd0, "R1", dly_sample, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(dly_sample == 10'd0, "R1", dly_sample, 0);

    // R8 and R9: delay sweep with a counting pattern, both sources
    for (int d = 0; d <= 15; d++) begin
      logic [9:0] hist [40];
      delay_sel = 4'(d);
      for (int i = 0; i < 40; i++) begin
        logic [9:0] v;
        v = 10'((d * 97 + i * 13 + 5) % 1024);
        hist[i] = v;
        src_sel = 1'(i % 2);
        play_sample = ~v;
        step(v, 1'b0, 1'b0);
        if (i >= d) begin
          check(dly_sample == hist[i - d], "R8", dly_sample, hist[i - d]);
          if (src_sel)
            check(proc_data == play_sample, "R9", proc_data, play_sample);
          else
            check(proc_data == hist[i - d], "R9", proc_data, hist[i - d]);
        end
      end
    end
    delay_sel = 4'd0;
    src_sel   = 1'b0;

    run(1'b0, 1, 2, 4, -1, "R2");   // follow mode ignores the pulse
    run(1'b1, -1, 0, 4, -1, "R3");  // no pulse, enable follows the run
    run(1'b1, 1, 3, 4, -1, "R4");   // mid-turn pulse, drop at turn 2
    run(1'b1, 1, TL - 1, 4, -1, "R4"); // pulse on the last cycle of a turn
    run(1'b1, 1, 0, 4, -1, "R5");   // pulse on the marker cycle
    run(1'b1, -1, 0, 4, 1, "R6");   // equal level does not stop
    run(1'b1, 1, 2, 2, -1, "R7");   // run ends inside the pulse turn
    run(1'b1, -1, 0, 3, -1, "R10"); // fresh run after idle pulses

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule